// File: doc/BRIEF.md
# Floating-point compare and select unit

This unit performs the single-precision operations that need no arithmetic: three ordered comparisons, minimum and maximum, sign negation, absolute value and a classification mask. A caller offers two 32-bit operands and a 3-bit operation code on a valid/ready input stream. Each result leaves on a valid/ready output stream as a 32-bit word. Depending on the operation, that word is a boolean in bit 0, one of the two operands, the first operand with its sign changed, or a one-hot class mask.

Every operation has a fixed latency of one or two cycles while the output side keeps `out_ready` high. Comparisons treat any operand whose exponent field is zero as a zero of the same sign. Minimum, maximum, sign changes and classification use the exact bit patterns, including subnormals. Results leave in the order their requests were accepted.

The input transfers when `in_valid` and `in_ready` are both high at a clock edge. The output transfers when `out_valid` and `out_ready` are both high. `in_ready` may depend on `in_op` in the same cycle. A caller must hold its request stable until it transfers. When the output is stalled, nothing inside the unit advances and no new request is taken.

Top module: `fp_cmpsel`

## Requirements
- R1: Operation codes on `in_op`: 0 less-than, 1 less-or-equal, 2 equal, 3 minimum, 4 maximum, 5 negate, 6 absolute value, 7 classify. A comparison returns 1 or 0 in bit 0 with bits 31:1 zero. It returns 0 when either operand is a NaN, and +0 compares equal to -0.
- R2: Comparisons treat an operand with exponent field 0 and nonzero fraction as a zero of its sign. For example, 0x00000001 equals 0x80000000.
- R3: For non-NaN operands, minimum returns a when a < b and b otherwise. Maximum returns b when a < b and a otherwise. Both order the operands by their exact values, including subnormals, so minimum(+0, -0) returns b.
- R4: If exactly one minimum/maximum operand is a NaN, the result is the other operand. If both are NaN, the result is 0x7FC00000.
- R5: Negate inverts bit 31 of a. Absolute value clears bit 31 of a. Both leave bits 30:0 unchanged, subnormals included.
- R6: Classify returns a one-hot mask in bits 9:0 with bits 31:10 zero. The mask bits are: bit 0 -inf, bit 1 negative normal, bit 2 negative subnormal, bit 3 -0, bit 4 +0, bit 5 positive subnormal, bit 6 positive normal, bit 7 +inf, bit 8 signalling NaN (fraction MSB 0), bit 9 quiet NaN (fraction MSB 1).
- R7: With `out_ready` high, codes 0, 1, 2, 5 and 6 give `out_valid` in the cycle after acceptance, and codes 3, 4 and 7 give it two cycles after acceptance.
- R8: Results leave in acceptance order, at most one per cycle. A one-cycle operation offered in the cycle after a two-cycle operation was accepted sees `in_ready` low for that one cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold and `in_ready` is low.
- R10: During and right after reset, `out_valid` is low. With the unit empty, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result word |

## Verification
A two-cycle operation (minimum, maximum, classify) accepted in one cycle and a one-cycle operation accepted in the next would both complete in the same cycle. The bench provokes this by issuing long and short operations back to back, both in directed pairs and in random mixes. Its behavioural model expects `in_ready` to drop for exactly that one cycle, and the exact latency of both results to hold. A second phase toggles `out_ready` at random to check that a stalled result stays put and that no request is taken under a stall.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;

  localparam int unsigned CLASS_W = 10;

  typedef enum logic [2:0] {
    OP_LT    = 3'd0,
    OP_LE    = 3'd1,
    OP_EQ    = 3'd2,
    OP_MIN   = 3'd3,
    OP_MAX   = 3'd4,
    OP_NEG   = 3'd5,
    OP_ABS   = 3'd6,
    OP_CLASS = 3'd7
  } fop_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic sub;
    logic norm;
    logic inf;
    logic snan;
    logic qnan;
  } fkind_t;

  function automatic logic op_is_long(fop_e op);
    return (op == OP_MIN) || (op == OP_MAX) || (op == OP_CLASS);
  endfunction

endpackage

// File: rtl/fpcs_kind.sv
module fpcs_kind import fpcs_pkg::*; #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] x,
  output fkind_t       k
);

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;
  logic             ex_top, ex_bot, fr_nz;

  always_comb begin
    ex     = x[W-2 -: EXP_W];
    fr     = x[MAN_W-1:0];
    ex_top = &ex;
    ex_bot = ~|ex;
    fr_nz  = |fr;
    k.sign = x[W-1];
    k.zero = ex_bot & ~fr_nz;
    k.sub  = ex_bot & fr_nz;
    k.norm = ~ex_top & ~ex_bot;
    k.inf  = ex_top & ~fr_nz;
    k.qnan = ex_top & fr_nz & fr[MAN_W-1];
    k.snan = ex_top & fr_nz & ~fr[MAN_W-1];
  end

endmodule

// File: rtl/fpcs_less.sv
module fpcs_less #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  parameter bit          FLUSH = 1'b0,
  localparam int unsigned W     = 1 + EXP_W + MAN_W,
  localparam int unsigned MAG_W = EXP_W + MAN_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         lt
);

  logic [MAG_W-1:0] mx, my;
  logic             nx, ny, sx, sy;

  always_comb begin
    mx = x[MAG_W-1:0];
    my = y[MAG_W-1:0];
    nx = (&x[MAG_W-1 -: EXP_W]) & (|x[MAN_W-1:0]);
    ny = (&y[MAG_W-1 -: EXP_W]) & (|y[MAN_W-1:0]);
    if (FLUSH && (x[MAG_W-1 -: EXP_W] == '0)) mx = '0;
    if (FLUSH && (y[MAG_W-1 -: EXP_W] == '0)) my = '0;
    sx = x[W-1];
    sy = y[W-1];
    if (nx || ny)                 lt = 1'b0;
    else if (mx == '0 && my == '0) lt = 1'b0;
    else if (sx != sy)            lt = sx;
    else if (!sx)                 lt = (mx < my);
    else                          lt = (my < mx);
  end

endmodule

// File: rtl/fpcs_select.sv
module fpcs_select import fpcs_pkg::*; #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  fop_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         a_lt_b,
  input  logic         b_nan,
  input  fkind_t       ka,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [CLASS_W-1:0] mask;
  logic               a_nan, take_a;

  always_comb begin
    mask    = '0;
    mask[0] = ka.sign & ka.inf;
    mask[1] = ka.sign & ka.norm;
    mask[2] = ka.sign & ka.sub;
    mask[3] = ka.sign & ka.zero;
    mask[4] = ~ka.sign & ka.zero;
    mask[5] = ~ka.sign & ka.sub;
    mask[6] = ~ka.sign & ka.norm;
    mask[7] = ~ka.sign & ka.inf;
    mask[8] = ka.snan;
    mask[9] = ka.qnan;
    a_nan   = ka.snan | ka.qnan;
    take_a  = (op == OP_MIN) ? a_lt_b : ~a_lt_b;
    if (op == OP_CLASS)      res = {{(W-CLASS_W){1'b0}}, mask};
    else if (a_nan && b_nan) res = CANON_NAN;
    else if (a_nan)          res = b;
    else if (b_nan)          res = a;
    else                     res = take_a ? a : b;
  end

endmodule

// File: rtl/fp_cmpsel.sv
module fp_cmpsel import fpcs_pkg::*; #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  // relation slots: flushed a<b, flushed b<a, exact a<b
  localparam int unsigned REL_AB   = 0;
  localparam int unsigned REL_BA   = 1;
  localparam int unsigned REL_TRUE = 2;
  localparam int unsigned N_REL    = 3;

  fop_e             op_in;
  fkind_t           kind_a;
  logic             a_nan, b_nan;
  logic [N_REL-1:0] rel;
  logic             lt_f, le_f, eq_f;
  logic [W-1:0]     short_res;
  logic             in_long, adv, accept;

  assign op_in = fop_e'(in_op);

  fpcs_kind #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_kind_a (
    .x(in_a),
    .k(kind_a)
  );

  assign a_nan = kind_a.snan | kind_a.qnan;
  assign b_nan = (&in_b[W-2 -: EXP_W]) & (|in_b[MAN_W-1:0]);

  for (genvar g = 0; g < N_REL; g++) begin : g_rel
    localparam bit SWAP = (g == REL_BA);
    localparam bit FL   = (g != REL_TRUE);
    fpcs_less #(.EXP_W(EXP_W), .MAN_W(MAN_W), .FLUSH(FL)) u_less (
      .x (SWAP ? in_b : in_a),
      .y (SWAP ? in_a : in_b),
      .lt(rel[g])
    );
  end

  assign lt_f = rel[REL_AB];
  assign le_f = ~rel[REL_BA] & ~a_nan & ~b_nan;
  assign eq_f = le_f & ~rel[REL_AB];

  always_comb begin
    short_res = '0;
    unique case (op_in)
      OP_LT:   short_res[0] = lt_f;
      OP_LE:   short_res[0] = le_f;
      OP_EQ:   short_res[0] = eq_f;
      OP_NEG:  short_res = {~in_a[W-1], in_a[W-2:0]};
      OP_ABS:  short_res = {1'b0, in_a[W-2:0]};
      default: short_res = '0;
    endcase
  end

  // stage 1: one-cycle results final, two-cycle operands held
  logic         s1_v, s1_long;
  fop_e         s1_op;
  logic [W-1:0] s1_a, s1_b, s1_res;
  logic         s1_lt, s1_bn;
  fkind_t       s1_ka;
  // stage 2: two-cycle results
  logic         s2_v;
  logic [W-1:0] s2_res, sel_res;

  assign out_valid = (s1_v & ~s1_long) | s2_v;
  assign out_data  = s2_v ? s2_res : s1_res;
  assign adv       = ~(out_valid & ~out_ready);
  assign in_long   = op_is_long(op_in);
  assign in_ready  = adv & ~(~in_long & s1_v & s1_long);
  assign accept    = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_long <= 1'b0;
      s2_v    <= 1'b0;
    end else if (adv) begin
      s1_v    <= accept;
      s1_long <= accept & in_long;
      s2_v    <= s1_v & s1_long;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && accept) begin
      s1_op  <= op_in;
      s1_a   <= in_a;
      s1_b   <= in_b;
      s1_res <= short_res;
      s1_lt  <= rel[REL_TRUE];
      s1_bn  <= b_nan;
      s1_ka  <= kind_a;
    end
    if (adv) s2_res <= sel_res;
  end

  fpcs_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_select (
    .op    (s1_op),
    .a     (s1_a),
    .b     (s1_b),
    .a_lt_b(s1_lt),
    .b_nan (s1_bn),
    .ka    (s1_ka),
    .res   (sel_res)
  );

endmodule

// File: rtl/fpcs_checker.sv
module fpcs_checker import fpcs_pkg::*; #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [2:0]   in_op,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         s1_v,
  input logic         s1_long,
  input logic         s2_v
);

  logic in_long, long_acc_q;
  assign in_long = op_is_long(fop_e'(in_op));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) long_acc_q <= 1'b0;
    else        long_acc_q <= in_valid & in_ready & in_long;
  end

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_short_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_long |=> out_valid);

  assert_long_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    long_acc_q && out_ready |=> out_valid);

  assert_single_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(s1_v && !s1_long && s2_v));

  assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_no_take_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

bind fp_cmpsel fpcs_checker #(.W(W)) u_fpcs_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_op    (in_op),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .s1_v     (s1_v),
  .s1_long  (s1_long),
  .s2_v     (s2_v)
);

// File: tb/tb_fp_cmpsel.sv
module tb_fp_cmpsel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [31:0] in_a = 32'd0;
  logic [31:0] in_b = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  fp_cmpsel dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  bit    bp_mode = 1'b0;
  bit    prev_long = 1'b0;
  bit    done = 1'b0;
  logic [31:0] qd[$];
  int          qdue[$];
  string       qtag[$];

  localparam int NP = 15;
  logic [31:0] pool [NP] = '{
    32'h00000000, 32'h80000000, 32'h3f800000, 32'hbf800000, 32'h40000000,
    32'h00000001, 32'h80000001, 32'h007fffff, 32'h00800000, 32'h7f800000,
    32'hff800000, 32'h7fc00000, 32'h7f800001, 32'hffc00001, 32'h7f7fffff};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic bit is_long(logic [2:0] op);
    return op == 3'd3 || op == 3'd4 || op == 3'd7;
  endfunction

  function automatic bit nan_f(logic [31:0] x);
    return x[30:23] == 8'hff && x[22:0] != 0;
  endfunction

  function automatic bit sub_f(logic [31:0] x);
    return x[30:23] == 8'h00 && x[22:0] != 0;
  endfunction

  function automatic int key_f(logic [31:0] x, bit flush);
    int m;
    m = (flush && x[30:23] == 8'h00) ? 0 : int'({1'b0, x[30:0]});
    return x[31] ? -m : m;
  endfunction

  function automatic logic [31:0] class_f(logic [31:0] x);
    int idx;
    if (nan_f(x))                 idx = x[22] ? 9 : 8;
    else if (x[30:23] == 8'hff)   idx = x[31] ? 0 : 7;
    else if (x[30:23] == 8'h00)   idx = (x[22:0] == 0) ? (x[31] ? 3 : 4) : (x[31] ? 2 : 5);
    else                          idx = x[31] ? 1 : 6;
    return 32'd1 << idx;
  endfunction

  function automatic logic [31:0] ref_f(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    bit na, nb;
    int ka, kb, ta, tb;
    na = nan_f(a); nb = nan_f(b);
    ka = key_f(a, 1'b1); kb = key_f(b, 1'b1);
    ta = key_f(a, 1'b0); tb = key_f(b, 1'b0);
    case (op)
      3'd0: return {31'd0, !na && !nb && ka < kb};
      3'd1: return {31'd0, !na && !nb && ka <= kb};
      3'd2: return {31'd0, !na && !nb && ka == kb};
      3'd3, 3'd4: begin
        if (na && nb) return 32'h7fc00000;
        if (na) return b;
        if (nb) return a;
        if (op == 3'd3) return (ta < tb) ? a : b;
        return (ta < tb) ? b : a;
      end
      3'd5: return {~a[31], a[30:0]};
      3'd6: return {1'b0, a[30:0]};
      default: return class_f(a);
    endcase
  endfunction

  function automatic string tag_f(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    if (op <= 3'd2) return (sub_f(a) || sub_f(b)) ? "R2" : "R1";
    if (op == 3'd3 || op == 3'd4) return (nan_f(a) || nan_f(b)) ? "R4" : "R3";
    if (op == 3'd7) return "R6";
    return "R5";
  endfunction

  function automatic logic [31:0] pick();
    if ($urandom % 2 == 0) return pool[$urandom % NP];
    return $urandom;
  endfunction

  // reference model and comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (!bp_mode && in_valid)
        chk(in_ready == !(!is_long(in_op) && prev_long), "R8", "in_ready",
            32'(in_ready), 32'(!(!is_long(in_op) && prev_long)));
      if (out_valid && !out_ready)
        chk(!in_ready, "R9", "in_ready while stalled", 32'(in_ready), 32'd0);
      if (out_valid) begin
        if (qd.size() == 0) chk(1'b0, "R8", "result with nothing pending", out_data, 32'd0);
        else begin
          chk(out_data === qd[0], qtag[0], "result", out_data, qd[0]);
          if (out_ready) begin
            if (!bp_mode) chk(cyc == qdue[0], "R7", "latency", 32'(cyc), 32'(qdue[0]));
            void'(qd.pop_front());
            void'(qdue.pop_front());
            void'(qtag.pop_front());
          end
        end
      end else if (!bp_mode && qd.size() > 0 && qdue[0] <= cyc)
        chk(1'b0, "R7", "missing result", 32'd0, qd[0]);
      prev_long = in_valid && in_ready && is_long(in_op);
      if (in_valid && in_ready) begin
        qd.push_back(ref_f(in_op, in_a, in_b));
        qdue.push_back(cyc + (is_long(in_op) ? 2 : 1));
        qtag.push_back(tag_f(in_op, in_a, in_b));
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? 1'($urandom % 2) : 1'b1;
  end

  task automatic send(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R10", "out_valid in reset", 32'(out_valid), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R10", "idle after reset",
        {30'd0, out_valid, in_ready}, 32'd1);
    @(posedge clk); #1;

    // every operation over every pair of special values
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < NP; i++)
        for (int j = 0; j < NP; j++)
          send(3'(op), pool[i], pool[j]);

    // R8: long then short back to back, to force the hold-off cycle
    for (int k = 0; k < 60; k++) begin
      send(3'(k % 2 == 0 ? 3 : 7), pick(), pick());
      send(3'(k % 3 == 0 ? 0 : 5), pick(), pick());
    end

    // random mix, full throughput output
    for (int k = 0; k < 1500; k++) begin
      if ($urandom % 4 == 0) idle(1);
      send(3'($urandom % 8), pick(), pick());
    end
    idle(5);

    // R9: random back-pressure
    bp_mode = 1'b1;
    for (int k = 0; k < 1500; k++) begin
      if ($urandom % 3 == 0) idle(1);
      send(3'($urandom % 8), pick(), pick());
    end
    while (qd.size() != 0) begin @(posedge clk); #1; end
    idle(3);
    bp_mode = 1'b0;
    idle(5);
    chk(qd.size() == 0, "R8", "pending results at end", 32'(qd.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end

endmodule